// File: doc/BRIEF.md
# I/O Page Soft-Switch Controller

This block sits on a processor bus and watches a 128-byte I/O page. Inside that page, addresses act as commands rather than storage. A read touches a switch just as a write does. The block keeps the machine state these switches control: a keyboard latch with a "key ready" flag in bit 7, four display-mode flags, a bank of general-purpose annunciator outputs and a speaker line. It also sends a one-cycle pulse to the display logic whenever a display-mode switch is touched.

A keyboard front end loads a key by pulsing `key_valid` with a 7-bit code. Software polls the latch at page offset 0x00 and then acknowledges the key by touching offset 0x10. Writes carry no meaning beyond the access itself, so the block has no write-data input. Read data is registered and appears in the cycle after the access. In every other cycle it is 0x00.

Top module: `softswitch_ctrl`

## Requirements
- R1: An access whose address lies outside the page at `PAGE_BASE` (upper address bits differ) changes no state and returns 0x00.
- R2: A `key_valid` pulse loads the latch with `{1, key_code}`. The latch holds that value until the next key or acknowledge.
- R3: A read at offset 0x00 places the latch value, as it stood before that edge, on `rd_data` in the next cycle.
- R4: A read or a write at offset 0x10 clears latch bit 7 and keeps bits 6:0. A read there returns 0x00.
- R5: When a key arrives in the same cycle as an acknowledge at 0x10, the new key wins and bit 7 ends up set.
- R6: An access at 0x50 selects graphics (`text_mode`=0) and an access at 0x51 selects text (`text_mode`=1). Reads and writes behave the same.
- R7: Offsets 0x52/0x53 clear/set `mixed_mode`, 0x54/0x55 clear/set `page2_sel`, and 0x56/0x57 clear/set `hires_mode`. In each pair the odd address sets the flag.
- R8: `disp_dirty` is high in the cycle after every access to 0x50–0x57, repeated ones included. It is low after any other cycle.
- R9: An access at 0x58+2n sets `annun[n]` and an access at 0x59+2n clears it, for n = 0..3.
- R10: Each access at 0x30 inverts `spkr`.
- R11: A read at any in-page offset other than 0x00 returns 0x00. An access at an offset with no assigned meaning (for example a write at 0x00 or any access at 0x20) changes no state.
- R12: After reset the block is in text mode, full screen, page 1 and low resolution, with the latch, annunciators, speaker, `rd_data` and `disp_dirty` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Full bus address |
| key_valid | input | 1 | One-cycle key arrival strobe |
| key_code | input | 7 | Code of the arriving key |
| rd_data | output | 8 | Registered read data, valid the cycle after a read |
| text_mode | output | 1 | 1 = text, 0 = graphics |
| mixed_mode | output | 1 | 1 = mixed text/graphics |
| page2_sel | output | 1 | 1 = display page 2 |
| hires_mode | output | 1 | 1 = high-resolution graphics |
| annun | output | NUM_ANN | Annunciator outputs |
| spkr | output | 1 | Speaker line, toggled per access |
| disp_dirty | output | 1 | One-cycle display configuration pulse |

## Verification
The mode switches are driven through a sequence that sets and clears every flag. Some steps use reads and some use writes, and some flags are set while others are already set. This shows that the right bit moves, that the access direction does not matter, and that the odd address is the one that sets. The key latch is tried with a key alone, an acknowledge by read, an acknowledge by write, and a key colliding with an acknowledge. This separates the clear, keep and priority cases. Out-of-page addresses that alias the in-page offsets, and unassigned offsets, are used to show that nothing moves when nothing should.

// File: rtl/softsw_pkg.sv
// Package: shared offsets, command record and reset values for the
// soft-switch controller. Assumes a 128-byte page (7 offset bits).
package softsw_pkg;
    localparam int OFS_W    = 7;
    localparam int NUM_MODE = 4;
    localparam int NUM_ANN  = 4;
    localparam int SEL_W    = $clog2(NUM_MODE);

    localparam logic [OFS_W-1:0] OFS_KEY  = 7'h00;
    localparam logic [OFS_W-1:0] OFS_ACK  = 7'h10;
    localparam logic [OFS_W-1:0] OFS_SPKR = 7'h30;
    // Groups of eight offsets selected by offset bits 6:3
    localparam logic [3:0] GRP_MODE = 4'hA;   // 0x50..0x57
    localparam logic [3:0] GRP_ANN  = 4'hB;   // 0x58..0x5F

    // Mode flag reset value: bit0 text, bit1 mixed, bit2 page2, bit3 hires
    localparam logic [NUM_MODE-1:0] MODE_RST = 4'b0001;
    localparam logic [NUM_ANN-1:0]  ANN_RST  = '0;

    typedef struct packed {
        logic             key_rd;    // read of the key latch
        logic             key_ack;   // acknowledge (clear ready bit)
        logic             spkr_tog;  // speaker toggle
        logic             mode_we;   // mode flag update
        logic [SEL_W-1:0] mode_sel;
        logic             mode_val;
        logic             ann_we;    // annunciator update
        logic [SEL_W-1:0] ann_sel;
        logic             ann_val;
    } sw_cmd_t;
endpackage

// File: rtl/ss_decode.sv
// Decoder: turns one bus access into a command record. Purely
// combinational. Assumes PAGE_BASE is aligned to 128 bytes.
module ss_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hC000
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output softsw_pkg::sw_cmd_t cmd
);
    import softsw_pkg::*;

    localparam int HI_W = ADDR_W - OFS_W;

    logic             in_page;
    logic [OFS_W-1:0] ofs;

    assign in_page = bus_sel && (bus_addr[ADDR_W-1:OFS_W] == PAGE_BASE[ADDR_W-1:OFS_W]);
    assign ofs     = bus_addr[OFS_W-1:0];

    // Map the offset to switch commands; odd address sets a mode flag,
    // even address sets an annunciator.
    always_comb begin
        cmd          = '0;
        cmd.key_rd   = in_page && !bus_we && (ofs == OFS_KEY);
        cmd.key_ack  = in_page && (ofs == OFS_ACK);
        cmd.spkr_tog = in_page && (ofs == OFS_SPKR);
        cmd.mode_we  = in_page && (ofs[6:3] == GRP_MODE);
        cmd.mode_sel = ofs[2:1];
        cmd.mode_val = ofs[0];
        cmd.ann_we   = in_page && (ofs[6:3] == GRP_ANN);
        cmd.ann_sel  = ofs[2:1];
        cmd.ann_val  = !ofs[0];
    end

    logic unused_hi;
    assign unused_hi = ^{HI_W{1'b0}};
endmodule

// File: rtl/ss_keylatch.sv
// Key latch: holds the last key code with a ready flag in bit 7.
// Assumes key_valid is a one-cycle pulse; arrival beats acknowledge.
module ss_keylatch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_valid,
    input  logic [6:0] key_code,
    input  logic       ack,
    output logic [7:0] key_q
);
    // Load on arrival, else drop the ready bit on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_q <= '0;
        else if (key_valid)
            key_q <= {1'b1, key_code};
        else if (ack)
            key_q <= {1'b0, key_q[6:0]};
    end
endmodule

// File: rtl/ss_flagbank.sv
// Flag bank: N independent flags, one selected per update and written
// with a given value. Assumes SEL_W is wide enough to index N flags.
module ss_flagbank #(
    parameter int           N     = 4,
    parameter int           SEL_W = 2,
    parameter logic [N-1:0] RST   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic             val,
    output logic [N-1:0]     q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Update flag i when it is the selected one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= RST[i];
            else if (we && (sel == SEL_W'(i)))
                q[i] <= val;
        end
    end
endmodule

// File: rtl/softswitch_ctrl.sv
// Top: soft-switch controller for one 128-byte I/O page. Every access,
// read or write, is a command. Read data is registered (one cycle).
// Assumes the bus presents at most one access per cycle.
module softswitch_ctrl #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hC000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       key_valid,
    input  logic [6:0]                 key_code,
    output logic [7:0]                 rd_data,
    output logic                       text_mode,
    output logic                       mixed_mode,
    output logic                       page2_sel,
    output logic                       hires_mode,
    output logic [softsw_pkg::NUM_ANN-1:0] annun,
    output logic                       spkr,
    output logic                       disp_dirty
);
    import softsw_pkg::*;

    sw_cmd_t               cmd;
    logic [7:0]            key_q;
    logic [NUM_MODE-1:0]   mode_q;

    ss_decode #(.ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE)) u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .cmd     (cmd)
    );

    ss_keylatch u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_valid(key_valid),
        .key_code (key_code),
        .ack      (cmd.key_ack),
        .key_q    (key_q)
    );

    ss_flagbank #(.N(NUM_MODE), .SEL_W(SEL_W), .RST(MODE_RST)) u_mode (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cmd.mode_we),
        .sel  (cmd.mode_sel),
        .val  (cmd.mode_val),
        .q    (mode_q)
    );

    ss_flagbank #(.N(NUM_ANN), .SEL_W(SEL_W), .RST(ANN_RST)) u_ann (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cmd.ann_we),
        .sel  (cmd.ann_sel),
        .val  (cmd.ann_val),
        .q    (annun)
    );

    // Speaker line flips on every access to its switch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spkr <= 1'b0;
        else if (cmd.spkr_tog)
            spkr <= !spkr;
    end

    // Read data: latch value for a key read, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= cmd.key_rd ? key_q : 8'h00;
    end

    // Display-dirty pulse follows each mode switch access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            disp_dirty <= 1'b0;
        else
            disp_dirty <= cmd.mode_we;
    end

    assign text_mode  = mode_q[0];
    assign mixed_mode = mode_q[1];
    assign page2_sel  = mode_q[2];
    assign hires_mode = mode_q[3];
endmodule

// File: rtl/ss_ctrl_check.sv
// Checker: temporal properties of the soft-switch controller, with its
// own address decode. Attached to the top by the bind below.
module ss_ctrl_check #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hC000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              key_valid,
    input logic [6:0]        key_code,
    input logic [7:0]        rd_data,
    input logic              text_mode,
    input logic              mixed_mode,
    input logic              page2_sel,
    input logic              hires_mode,
    input logic [3:0]        annun,
    input logic              spkr,
    input logic              disp_dirty,
    input logic [7:0]        key_q
);
    logic       hit;
    logic       away;
    logic [6:0] o;
    logic [3:0] flags;

    assign hit   = bus_sel && (bus_addr[ADDR_W-1:7] == PAGE_BASE[ADDR_W-1:7]);
    assign away  = bus_sel && !hit;
    assign o     = bus_addr[6:0];
    assign flags = {hires_mode, page2_sel, mixed_mode, text_mode};

    p_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
        away && !key_valid |=> $stable(key_q) && $stable(flags) && $stable(annun)
                               && $stable(spkr) && rd_data == 8'h00);
    p_key_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> key_q == {1'b1, $past(key_code)});
    p_key_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !bus_we && o == 7'h00 |=> rd_data == $past(key_q));
    p_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit && o == 7'h10 && !key_valid |=> key_q == {1'b0, $past(key_q[6:0])});
    p_ack_loses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && o == 7'h10 && key_valid |=> key_q[7]);
    p_graphics_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit && o == 7'h50 |=> !text_mode);
    p_hires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit && o == 7'h57 |=> hires_mode);
    p_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit && o[6:3] == 4'hA |=> disp_dirty);
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && o[6:3] == 4'hA) |=> !disp_dirty && $stable(flags));
    p_ann_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit && o == 7'h58 |=> annun[0]);
    p_spkr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit && o == 7'h30 |=> spkr != $past(spkr));
    p_zero_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && !bus_we && o == 7'h00) |=> rd_data == 8'h00);
endmodule

bind softswitch_ctrl ss_ctrl_check #(.ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .key_valid (key_valid),
    .key_code  (key_code),
    .rd_data   (rd_data),
    .text_mode (text_mode),
    .mixed_mode(mixed_mode),
    .page2_sel (page2_sel),
    .hires_mode(hires_mode),
    .annun     (annun),
    .spkr      (spkr),
    .disp_dirty(disp_dirty),
    .key_q     (key_q)
);

// File: tb/softswitch_ctrl_test.sv
// Bench: a vector table walks the mode switches, then directed tests
// cover reset, the key latch, annunciators, speaker and ignored accesses.
module softswitch_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        key_valid = 1'b0;
    logic [6:0]  key_code = '0;
    logic [7:0]  rd_data;
    logic        text_mode, mixed_mode, page2_sel, hires_mode, spkr, disp_dirty;
    logic [3:0]  annun;
    int          total = 0;
    int          bad = 0;

    always #5 clk = !clk;

    softswitch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .key_valid(key_valid), .key_code(key_code),
        .rd_data(rd_data), .text_mode(text_mode), .mixed_mode(mixed_mode),
        .page2_sel(page2_sel), .hires_mode(hires_mode), .annun(annun),
        .spkr(spkr), .disp_dirty(disp_dirty)
    );

    // Entry: {we, offset[6:0], expected rd_data[7:0], expected {hires,page2,mixed,text}}
    localparam logic [19:0] VEC [10] = '{
        {1'b0, 7'h50, 8'h00, 4'b0000},
        {1'b1, 7'h53, 8'h00, 4'b0010},
        {1'b0, 7'h55, 8'h00, 4'b0110},
        {1'b1, 7'h57, 8'h00, 4'b1110},
        {1'b0, 7'h51, 8'h00, 4'b1111},
        {1'b0, 7'h52, 8'h00, 4'b1101},
        {1'b1, 7'h54, 8'h00, 4'b1001},
        {1'b0, 7'h56, 8'h00, 4'b0001},
        {1'b0, 7'h20, 8'h00, 4'b0001},
        {1'b1, 7'h50, 8'h00, 4'b0000}
    };

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; returns at the falling edge after the capturing edge.
    task automatic access(logic we, logic [15:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic key(logic [6:0] c);
        @(negedge clk);
        key_valid = 1'b1; key_code = c;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    function automatic logic [7:0] flags();
        return {4'b0, hires_mode, page2_sel, mixed_mode, text_mode};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 flags", flags(), 8'h01);
        chk("R12 annun", {4'b0, annun}, 8'h00);
        chk("R12 spkr/dirty", {6'b0, spkr, disp_dirty}, 8'h00);
        chk("R12 rd_data", rd_data, 8'h00);
        access(1'b0, 16'hC000);
        chk("R12 latch", rd_data, 8'h00);

        // R6 R7 R8 R11: table walk of the mode switches
        for (int i = 0; i < 10; i++) begin
            access(VEC[i][19], {9'h180, VEC[i][18:12]});
            chk("R6 R7 flags", flags(), {4'b0, VEC[i][3:0]});
            chk("R11 rd_data", rd_data, VEC[i][11:4]);
            chk("R8 dirty", {7'b0, disp_dirty}, {7'b0, VEC[i][18:15] == 4'hA});
            @(negedge clk);
            chk("R8 dirty drops", {7'b0, disp_dirty}, 8'h00);
        end

        // R8: back-to-back repeated access keeps the pulse high
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 16'hC050;
        @(negedge clk);
        chk("R8 repeat 1", {7'b0, disp_dirty}, 8'h01);
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R8 repeat 2", {7'b0, disp_dirty}, 8'h01);

        // R2 R3: key arrival then read
        key(7'h41);
        access(1'b0, 16'hC000);
        chk("R2 R3 key read", rd_data, 8'hC1);
        // R4: acknowledge by read
        access(1'b0, 16'hC010);
        chk("R4 ack read data", rd_data, 8'h00);
        access(1'b0, 16'hC000);
        chk("R4 ack by read", rd_data, 8'h41);
        // R4: acknowledge by write
        key(7'h5A);
        access(1'b1, 16'hC010);
        access(1'b0, 16'hC000);
        chk("R4 ack by write", rd_data, 8'h5A);
        // R5: key collides with acknowledge
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 16'hC010;
        key_valid = 1'b1; key_code = 7'h33;
        @(negedge clk);
        bus_sel = 1'b0; key_valid = 1'b0;
        access(1'b0, 16'hC000);
        chk("R5 key wins", rd_data, 8'hB3);

        // R1: aliasing addresses outside the page
        access(1'b0, 16'hC090);
        access(1'b1, 16'hC810);
        access(1'b0, 16'hD030);
        chk("R1 flags", flags(), 8'h00);
        chk("R1 spkr", {7'b0, spkr}, 8'h00);
        access(1'b0, 16'h4000);
        chk("R1 rd_data", rd_data, 8'h00);
        access(1'b0, 16'hC000);
        chk("R1 latch kept", rd_data, 8'hB3);

        // R11: write at 0x00 and access at 0x20 change nothing; 0x7F reads 0
        access(1'b1, 16'hC000);
        access(1'b1, 16'hC020);
        access(1'b0, 16'hC07F);
        chk("R11 read 7F", rd_data, 8'h00);
        access(1'b0, 16'hC000);
        chk("R11 latch kept", rd_data, 8'hB3);

        // R9: annunciators
        access(1'b1, 16'hC058);
        chk("R9 set 0", {4'b0, annun}, 8'h01);
        access(1'b0, 16'hC05F);
        chk("R9 clear 3 idle", {4'b0, annun}, 8'h01);
        access(1'b0, 16'hC05E);
        chk("R9 set 3", {4'b0, annun}, 8'h09);
        chk("R9 no dirty", {7'b0, disp_dirty}, 8'h00);
        access(1'b1, 16'hC059);
        chk("R9 clear 0", {4'b0, annun}, 8'h08);
        access(1'b0, 16'hC05A);
        chk("R9 set 1", {4'b0, annun}, 8'h0A);

        // R10: speaker toggle
        access(1'b0, 16'hC030);
        chk("R10 toggle on", {7'b0, spkr}, 8'h01);
        access(1'b1, 16'hC030);
        chk("R10 toggle off", {7'b0, spkr}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule